// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Pin Override

This block is one eight-pin general-purpose I/O port. It holds a direction register and a port register. When a pin is an output, the port register gives its drive level. When a pin is an input, the port register turns on its pull-up. Each pad input passes through a two-flop synchronizer. Software reads the synchronized value, and the block also hands it to on-chip peripherals.

On-chip peripherals can take over some of the pins. They can set the pin's direction, drive value, pull-up and digital-input enable. The peripherals are:
- an SPI unit, in master or slave role, on bits 5 to 2;
- three timer compare outputs, on bits 3 to 1;
- a divided-clock output and a capture input, on bit 0;
- an oscillator/clock mode, on bits 7 and 6.

A pin-change detector raises a pulse when a masked, synchronized input changes. The SPI engine, the timers, the oscillator and the interrupt controller are outside the block. They appear here only as ports.

Write transfers use `wr_sel`: 0 selects the direction register and 1 selects the port register. Reads use `rd_sel`: 0 returns direction, 1 returns port, 2 returns the synchronized pins and 3 returns zero.

Top module: `gpio_altport`

## Requirements
- R1: While `rst_n` is low, the direction and port registers are 0, so with `clkout_en` low every `pad_oe` bit is 0.
- R2: With no override active, `pad_oe` equals the direction register and `pad_out` equals the port register. `pad_pu` equals the port register ANDed with the inverted direction register, and is 0 everywhere when `pull_up_off` is 1. A write with `wr_en` high lands on the next rising edge and reads back through `rd_data`.
- R3: A level applied on `pad_in` appears at the pin readback (`rd_sel`=2) after two rising edges and not after one.
- R4: With `spi_en`=1 and `spi_master`=0 (slave), bits 5, 3 and 2 are inputs regardless of their direction bits. Bit 4 follows its direction bit and drives `spi_miso_out`.
- R5: With `spi_en`=1 and `spi_master`=1, bit 4 is an input regardless of its direction bit. Bits 5 and 3 follow their direction bits, and bit 5 drives `spi_sck_out`.
- R6: On a pin forced to input by the SPI unit, `pad_pu` is 1 exactly when its port bit is 1 and `pull_up_off` is 0. No pin ever has `pad_pu` and `pad_oe` both 1.
- R7: Bit 3 drives `(spi_mosi_out AND master-mode) OR (cmp_a AND cmp_a_en)` whenever master mode or `cmp_a_en` is active.
- R8: A compare enable replaces only the drive value: `cmp_b` goes to bit 2 and `cmp_c` to bit 1. The pin is enabled as an output only when its direction bit is 1.
- R9: With `clkout_en`=1, bit 0 is an output driving `clk_div` regardless of its direction and port bits, including while `rst_n` is low.
- R10: With `osc_mode`=1, bits 7 and 6 have `pad_oe`, `pad_out` and `pad_pu` equal to 0. The direction, port and pin readbacks return 0 in those two bits.
- R11: `pin_change` is high for exactly one cycle, two rising edges after a masked pin changes, and only when `pc_group_en`=1. A pin in oscillator mode still senses when its mask bit and the group enable are both 1.
- R12: `spi_sck_in`, `spi_miso_in`, `spi_mosi_in`, `spi_ss_in` and `capture_in` are the synchronized values of bits 5, 4, 3, 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 direction, 1 port |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select: 0 direction, 1 port, 2 pins |
| rd_data | output | 8 | Read data |
| pull_up_off | input | 1 | Global pull-up disable |
| spi_en | input | 1 | SPI unit enabled |
| spi_master | input | 1 | SPI role: 1 master, 0 slave |
| spi_sck_out | input | 1 | Serial clock from SPI engine (master) |
| spi_mosi_out | input | 1 | Controller-out data from SPI engine (master) |
| spi_miso_out | input | 1 | Controller-in data from SPI engine (slave) |
| spi_sck_in | output | 1 | Synchronized bit 5 |
| spi_miso_in | output | 1 | Synchronized bit 4 |
| spi_mosi_in | output | 1 | Synchronized bit 3 |
| spi_ss_in | output | 1 | Synchronized bit 2 |
| cmp_a_en | input | 1 | Compare output A enable (bit 3) |
| cmp_a | input | 1 | Compare output A level |
| cmp_b_en | input | 1 | Compare output B enable (bit 2) |
| cmp_b | input | 1 | Compare output B level |
| cmp_c_en | input | 1 | Compare output C enable (bit 1) |
| cmp_c | input | 1 | Compare output C level |
| clkout_en | input | 1 | Divided-clock output option |
| clk_div | input | 1 | Divided clock |
| capture_in | output | 1 | Synchronized bit 0 for timer capture |
| osc_mode | input | 1 | Bits 7 and 6 used as oscillator/clock pins |
| pc_mask | input | 8 | Per-pin pin-change mask |
| pc_group_en | input | 1 | Pin-change group enable |
| pin_change | output | 1 | Pin-change pulse |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad drive values |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The hardest case to reach is a pin in oscillator mode that still feeds the pin-change detector. That only happens when both its mask bit and the group enable are set, while its readback must stay zero. The stimulus first lets the synchronizer settle with oscillator mode on, then toggles bit 7 with the mask set. It checks for a pulse two edges later and a zero readback. It then clears the group enable and toggles again, expecting no pulse. A second hard case is the divided clock appearing during reset, before any register exists. The bench drives `clk_div` while `rst_n` is still low.

// File: rtl/gpio_altport.sv
module gpio_altport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         pull_up_off,
  input  logic         spi_en,
  input  logic         spi_master,
  input  logic         spi_sck_out,
  input  logic         spi_mosi_out,
  input  logic         spi_miso_out,
  output logic         spi_sck_in,
  output logic         spi_miso_in,
  output logic         spi_mosi_in,
  output logic         spi_ss_in,
  input  logic         cmp_a_en,
  input  logic         cmp_a,
  input  logic         cmp_b_en,
  input  logic         cmp_b,
  input  logic         cmp_c_en,
  input  logic         cmp_c,
  input  logic         clkout_en,
  input  logic         clk_div,
  output logic         capture_in,
  input  logic         osc_mode,
  input  logic [W-1:0] pc_mask,
  input  logic         pc_group_en,
  output logic         pin_change,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  localparam logic [W-1:0] OSC_PINS = W'(8'hC0);

  logic [W-1:0] dir_q, port_q, sync1, sync2, prev;
  logic [W-1:0] osc_mask, in_en;
  logic spi_s, spi_m;

  assign spi_s    = spi_en & ~spi_master;
  assign spi_m    = spi_en &  spi_master;
  assign osc_mask = osc_mode ? OSC_PINS : '0;
  assign in_en    = ~osc_mask | (pc_mask & {W{pc_group_en}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q  <= '0;
      port_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) port_q <= wr_data;
      else        dir_q  <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pad_in & in_en;
      sync2 <= sync1;
      prev  <= sync2;
    end

  always_comb begin
    pad_oe  = dir_q;
    pad_out = port_q;
    if (spi_s) begin
      pad_oe[5]  = 1'b0;
      pad_oe[3]  = 1'b0;
      pad_oe[2]  = 1'b0;
      pad_out[4] = spi_miso_out;
    end
    if (spi_m) begin
      pad_oe[4]  = 1'b0;
      pad_out[5] = spi_sck_out;
    end
    if (spi_m | cmp_a_en) pad_out[3] = (spi_m & spi_mosi_out) | (cmp_a_en & cmp_a);
    if (cmp_b_en) pad_out[2] = cmp_b;
    if (cmp_c_en) pad_out[1] = cmp_c;
    if (clkout_en) begin
      pad_oe[0]  = 1'b1;
      pad_out[0] = clk_div;
    end
    pad_oe  = pad_oe  & ~osc_mask;
    pad_out = pad_out & ~osc_mask;
    pad_pu  = ~pad_oe & port_q & ~osc_mask & {W{~pull_up_off}};
  end

  always_comb
    case (rd_sel)
      2'd0:    rd_data = dir_q  & ~osc_mask;
      2'd1:    rd_data = port_q & ~osc_mask;
      2'd2:    rd_data = sync2  & ~osc_mask;
      default: rd_data = '0;
    endcase

  assign spi_sck_in  = sync2[5];
  assign spi_miso_in = sync2[4];
  assign spi_mosi_in = sync2[3];
  assign spi_ss_in   = sync2[2];
  assign capture_in  = sync2[0];
  assign pin_change  = pc_group_en & |((sync2 ^ prev) & pc_mask);
endmodule

// File: rtl/gpio_altport_checks.sv
module gpio_altport_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_en,
  input logic       spi_master,
  input logic       pull_up_off,
  input logic       clkout_en,
  input logic       clk_div,
  input logic       osc_mode,
  input logic [7:0] pad_oe,
  input logic [7:0] pad_out,
  input logic [7:0] pad_pu
);
  p_slave_inputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> (pad_oe[5] == 1'b0 && pad_oe[3] == 1'b0 && pad_oe[2] == 1'b0));

  p_master_miso_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> pad_oe[4] == 1'b0);

  p_pu_not_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == 8'h00);

  p_pu_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pull_up_off |-> pad_pu == 8'h00);

  p_clkout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> (pad_oe[0] && pad_out[0] == clk_div));

  p_osc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    osc_mode |-> (pad_oe[7:6] == 2'b00 && pad_out[7:6] == 2'b00 && pad_pu[7:6] == 2'b00));
endmodule

bind gpio_altport gpio_altport_checks u_checks (
  .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .spi_master(spi_master),
  .pull_up_off(pull_up_off), .clkout_en(clkout_en), .clk_div(clk_div),
  .osc_mode(osc_mode), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/gpio_altport_test.sv
module gpio_altport_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rd_sel = 0;
  logic [7:0] rd_data;
  logic pull_up_off = 0, spi_en = 0, spi_master = 0;
  logic spi_sck_out = 0, spi_mosi_out = 0, spi_miso_out = 0;
  logic spi_sck_in, spi_miso_in, spi_mosi_in, spi_ss_in, capture_in, pin_change;
  logic cmp_a_en = 0, cmp_a = 0, cmp_b_en = 0, cmp_b = 0, cmp_c_en = 0, cmp_c = 0;
  logic clkout_en = 0, clk_div = 0, osc_mode = 0, pc_group_en = 0;
  logic [7:0] pc_mask = 0, pad_in = 0;
  logic [7:0] pad_oe, pad_out, pad_pu;
  int checks = 0, errors = 0;

  always #2ns clk = ~clk;

  gpio_altport uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick(1);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s; #0.1ns; v = rd_data;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    // R9 during reset
    clkout_en = 1;
    for (int i = 0; i < 2; i++) begin
      clk_div = i[0]; tick(1);
      chk("R9 reset oe0", {7'd0, pad_oe[0]}, 8'h01);
      chk("R9 reset out0", {7'd0, pad_out[0]}, {7'd0, i[0]});
    end
    clkout_en = 0; #0.1ns;
    chk("R1 reset oe", pad_oe, 8'h00);
    rd(0, v); chk("R1 reset dir", v, 8'h00);
    rd(1, v); chk("R1 reset port", v, 8'h00);
    rst_n = 1; tick(1);

    // R2 sweep
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d, p;
      d = i[7:0]; p = 8'(i * 37 + 11);
      pull_up_off = i[2];
      wr(0, d); wr(1, p);
      chk("R2 oe", pad_oe, d);
      chk("R2 out", pad_out, p);
      chk("R2 pu", pad_pu, pull_up_off ? 8'h00 : (~d & p));
      rd(0, v); chk("R2 dir rd", v, d);
      rd(1, v); chk("R2 port rd", v, p);
    end
    pull_up_off = 0;

    // R3 / R12 sync
    for (int i = 0; i < 16; i++) begin
      logic [7:0] old, nv;
      rd(2, old);
      nv = 8'(i * 91 + 5);
      pad_in = nv;
      tick(1); rd(2, v); chk("R3 one edge", v, old);
      tick(1); rd(2, v); chk("R3 two edges", v, nv);
      chk("R12 taps", {3'd0, spi_sck_in, spi_miso_in, spi_mosi_in, spi_ss_in, capture_in},
          {3'd0, nv[5], nv[4], nv[3], nv[2], nv[0]});
    end

    // R4 slave
    wr(0, 8'hFF); wr(1, 8'hFF);
    spi_en = 1; spi_master = 0;
    for (int i = 0; i < 2; i++) begin
      spi_miso_out = i[0]; #0.1ns;
      chk("R4 slave oe", pad_oe, 8'hD3);
      chk("R4 slave miso", {7'd0, pad_out[4]}, {7'd0, i[0]});
    end
    chk("R6 slave pu", pad_pu, 8'h2C);
    pull_up_off = 1; #0.1ns;
    chk("R6 slave pu off", pad_pu, 8'h00);
    pull_up_off = 0;
    wr(1, 8'hDB); chk("R6 slave pu port", pad_pu, 8'h08);
    wr(1, 8'hFF);

    // R5 master and R7
    spi_master = 1;
    for (int i = 0; i < 8; i++) begin
      spi_sck_out = i[0]; spi_mosi_out = i[1]; cmp_a = i[2]; cmp_a_en = 0; #0.1ns;
      chk("R5 master oe", pad_oe, 8'hEF);
      chk("R5 master sck", {7'd0, pad_out[5]}, {7'd0, i[0]});
      chk("R7 mosi only", {7'd0, pad_out[3]}, {7'd0, i[1]});
      cmp_a_en = 1; #0.1ns;
      chk("R7 or", {7'd0, pad_out[3]}, {7'd0, i[1] | i[2]});
    end
    chk("R6 master pu", pad_pu, 8'h10);
    spi_en = 0; spi_master = 0;
    for (int i = 0; i < 2; i++) begin
      cmp_a = i[0]; #0.1ns;
      chk("R7 cmp only", {7'd0, pad_out[3]}, {7'd0, i[0]});
    end
    cmp_a_en = 0;

    // R8 compare outputs
    cmp_b_en = 1; cmp_c_en = 1;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = {6'd0, i[2], 1'b0} << 1 | {6'd0, i[2], 1'b0};
      cmp_b = i[0]; cmp_c = i[1];
      wr(0, d); wr(1, 8'h00);
      chk("R8 oe", pad_oe, d);
      chk("R8 vals", pad_out & 8'h06, {5'd0, i[0], i[1], 1'b0});
    end
    cmp_b_en = 0; cmp_c_en = 0;

    // R9 after reset
    wr(0, 8'h00); wr(1, 8'h00);
    clkout_en = 1;
    for (int i = 0; i < 2; i++) begin
      clk_div = i[0]; #0.1ns;
      chk("R9 oe0", {7'd0, pad_oe[0]}, 8'h01);
      chk("R9 out0", {7'd0, pad_out[0]}, {7'd0, i[0]});
    end
    clkout_en = 0;

    // R10 oscillator pins
    wr(0, 8'hFF); wr(1, 8'hFF); pad_in = 8'hFF;
    osc_mode = 1; tick(3);
    chk("R10 oe", pad_oe & 8'hC0, 8'h00);
    chk("R10 out", pad_out & 8'hC0, 8'h00);
    chk("R10 pu", pad_pu & 8'hC0, 8'h00);
    rd(0, v); chk("R10 dir rd", v, 8'h3F);
    rd(1, v); chk("R10 port rd", v, 8'h3F);
    rd(2, v); chk("R10 pin rd", v, 8'h3F);

    // R11 pin change
    pc_mask = 8'h81; pc_group_en = 1; pad_in = 8'h00; tick(4);
    chk("R11 idle", {7'd0, pin_change}, 8'h00);
    pad_in = 8'h80; tick(1);
    chk("R11 not yet", {7'd0, pin_change}, 8'h00);
    tick(1); chk("R11 osc pulse", {7'd0, pin_change}, 8'h01);
    rd(2, v); chk("R11 osc rd zero", v, 8'h00);
    tick(1); chk("R11 one cycle", {7'd0, pin_change}, 8'h00);
    pad_in = 8'h82; tick(3);
    chk("R11 unmasked", {7'd0, pin_change}, 8'h00);
    pad_in = 8'h83; tick(2);
    chk("R11 bit0 pulse", {7'd0, pin_change}, 8'h01);
    pc_group_en = 0; tick(2);
    pad_in = 8'h02; tick(2);
    chk("R11 group off", {7'd0, pin_change}, 8'h00);
    tick(1);
    chk("R11 group off late", {7'd0, pin_change}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule